// File: doc/BRIEF.md
# Reset and Interrupt Entry Sequencer

This block drives the bus, one cycle at a time, while an 8-bit processor with a 16-bit address bus and a stack in page one enters a new program flow. After reset is released it performs three stack cycles, reads a two-byte vector and fetches the first opcode from the address that vector gives. It then hands control to an execution unit. The block owns the stack pointer, the instruction register and the program counter.

The same sequence serves hardware interrupts and the break instruction. In those cases the three stack cycles are real writes that save the return address and the status byte. On reset they are reads whose data is thrown away, but they still move the pointer down. A cleared pointer therefore settles at $FD without any explicit load.

Between sequences the block waits in a run state and presents the program counter as a read address. In that state it accepts entry requests, with the non-maskable one taking priority.

Top module: `entry_seq`

## Requirements
- R1: While `rst_n` is low, `rw` is 1 (read), `sp` is $00, `ir` is $00, `done` is 0 and `int_mask` is 0.
- R2: On the first clock after `rst_n` rises, three read cycles follow at $0100, $01FF and $01FE, in that order. `sp` steps down by one after each of them and ends at $FD.
- R3: After the stack cycles the vector low byte is read, then the high byte at the next address. On reset these addresses are $FFFC and $FFFD. The next cycle fetches from {high, low} with `done` at 1 on that cycle only.
- R4: `ir` reads $00 during every stack and vector cycle of any entry sequence. The byte on `din` during the fetch cycle is loaded into `ir`.
- R5: For an interrupt or break entry, the three stack cycles are writes (`rw` = 0) at $0100+`sp`, with `sp` decremented after each. `dout` carries the PC high byte, then the PC low byte, then `psr_in` unchanged.
- R6: A non-maskable entry reads its vector from $FFFA/$FFFB. A maskable interrupt or a break reads from $FFFE/$FFFF.
- R7: In the run state a non-maskable request wins over a maskable one, and a maskable one wins over break. Requests that arrive while a sequence is in progress are ignored.
- R8: `int_mask` is set by the start of any entry sequence and stays at 1 afterwards, and it is 1 on the fetch cycle.
- R9: After the fetch cycle `pc` equals the vector plus one. In the run state `addr` follows `pc` as a read and stays steady while no request is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| nmi_req | input | 1 | Non-maskable entry request |
| irq_req | input | 1 | Maskable entry request |
| brk_req | input | 1 | Break instruction entry request |
| psr_in | input | 8 | Status byte to be saved on entry |
| din | input | 8 | Read data bus |
| addr | output | 16 | Address bus |
| rw | output | 1 | 1 = read cycle, 0 = write cycle |
| dout | output | 8 | Write data bus |
| done | output | 1 | High on the first opcode fetch cycle |
| sp | output | 8 | Stack pointer |
| ir | output | 8 | Instruction register |
| pc | output | 16 | Program counter |
| int_mask | output | 1 | Interrupt-disable status bit |

## Verification
The hardest case to reach is a request that lands while a sequence is already under way, or a reset that cuts a sequence short. Neither can happen until a full reset entry has finished and the block sits in its run state. The stimulus first walks the reset sequence cycle by cycle from a table. It then raises the non-maskable and maskable requests together and holds the maskable one through the stack cycles. The vector and the later run state must show that only the non-maskable entry took effect. A reset asserted in the middle of an interrupt push is then followed by a second walk of the reset table from a cleared pointer.

// File: rtl/entry_seq_pkg.sv
package entry_seq_pkg;

   typedef enum logic [2:0] {
      ST_HOLD,
      ST_STACK,
      ST_VLO,
      ST_VHI,
      ST_FETCH,
      ST_RUN
   } seq_state_t;

   typedef enum logic [1:0] {
      EK_RESET,
      EK_NMI,
      EK_IRQ,
      EK_BRK
   } entry_kind_t;

   localparam int unsigned PUSH_SLOTS = 3;

endpackage

// File: rtl/entry_arbiter.sv
module entry_arbiter
   import entry_seq_pkg::*;
#(
   parameter bit BRK_OVER_IRQ = 1'b0
) (
   input  logic        nmi_req,
   input  logic        irq_req,
   input  logic        brk_req,
   output logic        take,
   output entry_kind_t kind
);

   assign take = nmi_req | irq_req | brk_req;

   generate
      if (BRK_OVER_IRQ) begin : g_brk_first
         always_comb begin
            if (nmi_req)      kind = EK_NMI;
            else if (brk_req) kind = EK_BRK;
            else              kind = EK_IRQ;
         end
      end else begin : g_irq_first
         always_comb begin
            if (nmi_req)      kind = EK_NMI;
            else if (irq_req) kind = EK_IRQ;
            else              kind = EK_BRK;
         end
      end
   endgenerate

endmodule

// File: rtl/entry_vec_sel.sv
module entry_vec_sel
   import entry_seq_pkg::*;
#(
   parameter int unsigned ADDR_W    = 16,
   parameter logic [ADDR_W-1:0] RESET_VEC = 16'hFFFC,
   parameter logic [ADDR_W-1:0] NMI_VEC   = 16'hFFFA,
   parameter logic [ADDR_W-1:0] IRQ_VEC   = 16'hFFFE
) (
   input  entry_kind_t       kind,
   output logic [ADDR_W-1:0] vec_lo,
   output logic [ADDR_W-1:0] vec_hi
);

   always_comb begin
      case (kind)
         EK_RESET: vec_lo = RESET_VEC;
         EK_NMI:   vec_lo = NMI_VEC;
         default:  vec_lo = IRQ_VEC;
      endcase
   end

   assign vec_hi = vec_lo + ADDR_W'(1);

endmodule

// File: rtl/entry_stack_ptr.sv
module entry_stack_ptr #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         dec,
   output logic [W-1:0] sp
);

   logic [W-1:0] sp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   sp_q <= '0;
      else if (dec) sp_q <= sp_q - W'(1);
   end

   assign sp = sp_q;

endmodule

// File: rtl/entry_seq.sv
module entry_seq
   import entry_seq_pkg::*;
#(
   parameter int unsigned DATA_W       = 8,
   parameter int unsigned ADDR_W       = 16,
   parameter logic [ADDR_W-DATA_W-1:0] STACK_PAGE = 'h01,
   parameter logic [ADDR_W-1:0] RESET_VEC = 16'hFFFC,
   parameter logic [ADDR_W-1:0] NMI_VEC   = 16'hFFFA,
   parameter logic [ADDR_W-1:0] IRQ_VEC   = 16'hFFFE,
   parameter bit BRK_OVER_IRQ = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              nmi_req,
   input  logic              irq_req,
   input  logic              brk_req,
   input  logic [DATA_W-1:0] psr_in,
   input  logic [DATA_W-1:0] din,
   output logic [ADDR_W-1:0] addr,
   output logic              rw,
   output logic [DATA_W-1:0] dout,
   output logic              done,
   output logic [DATA_W-1:0] sp,
   output logic [DATA_W-1:0] ir,
   output logic [ADDR_W-1:0] pc,
   output logic              int_mask
);

   localparam int unsigned SLOT_W   = $clog2(PUSH_SLOTS);
   localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(PUSH_SLOTS - 1);

   generate
      if (ADDR_W != 2 * DATA_W) begin : g_bad_width
         $error("entry_seq: ADDR_W must be twice DATA_W");
      end
      if (RESET_VEC[0] || NMI_VEC[0] || IRQ_VEC[0]) begin : g_bad_vec
         $error("entry_seq: vector addresses must be even");
      end
   endgenerate

   seq_state_t        state_q;
   entry_kind_t       kind_q;
   logic [SLOT_W-1:0] slot_q;
   logic [ADDR_W-1:0] pc_q;
   logic [DATA_W-1:0] ir_q;
   logic [DATA_W-1:0] vlo_q;
   logic              mask_q;

   logic              take;
   entry_kind_t       req_kind;
   logic [ADDR_W-1:0] vec_lo;
   logic [ADDR_W-1:0] vec_hi;
   logic              in_stack;
   logic              in_seq;
   logic              start;

   entry_arbiter #(.BRK_OVER_IRQ(BRK_OVER_IRQ)) u_arb (
      .nmi_req (nmi_req),
      .irq_req (irq_req),
      .brk_req (brk_req),
      .take    (take),
      .kind    (req_kind)
   );

   entry_vec_sel #(
      .ADDR_W    (ADDR_W),
      .RESET_VEC (RESET_VEC),
      .NMI_VEC   (NMI_VEC),
      .IRQ_VEC   (IRQ_VEC)
   ) u_vec (
      .kind   (kind_q),
      .vec_lo (vec_lo),
      .vec_hi (vec_hi)
   );

   assign in_stack = (state_q == ST_STACK);
   assign in_seq   = in_stack || (state_q == ST_VLO) || (state_q == ST_VHI);
   assign start    = (state_q == ST_HOLD) || ((state_q == ST_RUN) && take);

   entry_stack_ptr #(.W(DATA_W)) u_sp (
      .clk   (clk),
      .rst_n (rst_n),
      .dec   (in_stack),
      .sp    (sp)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_HOLD;
         kind_q  <= EK_RESET;
         slot_q  <= '0;
         pc_q    <= '0;
         ir_q    <= '0;
         vlo_q   <= '0;
         mask_q  <= 1'b0;
      end else begin
         if (start) begin
            state_q <= ST_STACK;
            kind_q  <= (state_q == ST_HOLD) ? EK_RESET : req_kind;
            slot_q  <= '0;
            ir_q    <= '0;
            mask_q  <= 1'b1;
         end else begin
            case (state_q)
               ST_STACK: begin
                  if (slot_q == LAST_SLOT) state_q <= ST_VLO;
                  slot_q <= slot_q + SLOT_W'(1);
               end
               ST_VLO: begin
                  vlo_q   <= din;
                  state_q <= ST_VHI;
               end
               ST_VHI: begin
                  pc_q    <= {din, vlo_q};
                  state_q <= ST_FETCH;
               end
               ST_FETCH: begin
                  ir_q    <= din;
                  pc_q    <= pc_q + ADDR_W'(1);
                  state_q <= ST_RUN;
               end
               default: state_q <= state_q;
            endcase
         end
      end
   end

   always_comb begin
      addr = pc_q;
      rw   = 1'b1;
      dout = '0;
      case (state_q)
         ST_STACK: begin
            addr = {STACK_PAGE, sp};
            if (kind_q != EK_RESET) begin
               rw = 1'b0;
               case (slot_q)
                  2'd0:    dout = pc_q[ADDR_W-1:DATA_W];
                  2'd1:    dout = pc_q[DATA_W-1:0];
                  default: dout = psr_in;
               endcase
            end
         end
         ST_VLO:  addr = vec_lo;
         ST_VHI:  addr = vec_hi;
         default: addr = pc_q;
      endcase
   end

   assign done     = (state_q == ST_FETCH);
   assign ir       = ir_q;
   assign pc       = pc_q;
   assign int_mask = mask_q;

endmodule

// File: rtl/entry_seq_checker.sv
module entry_seq_checker #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned ADDR_W = 16,
   parameter logic [ADDR_W-DATA_W-1:0] STACK_PAGE = 'h01
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic              rw,
   input logic              done,
   input logic [DATA_W-1:0] sp,
   input logic [DATA_W-1:0] ir,
   input logic [ADDR_W-1:0] pc,
   input logic              int_mask,
   input logic              in_stack,
   input logic              in_seq
);

   always @(negedge clk) begin
      if (!rst_n) begin
         assert_reset_hold_R1: assert (rw && sp == '0 && ir == '0 && !done && !int_mask);
      end
   end

   assert_stack_page_R2: assert property (@(posedge clk) disable iff (!rst_n)
      in_stack |-> addr[ADDR_W-1:DATA_W] == STACK_PAGE);

   assert_sp_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      in_stack |=> sp == $past(sp) - DATA_W'(1));

   assert_fetch_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> rw);

   assert_ir_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      in_seq |-> ir == '0);

   assert_write_on_stack_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !rw |-> addr[ADDR_W-1:DATA_W] == STACK_PAGE);

   assert_mask_on_fetch_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> int_mask);

   assert_mask_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      int_mask |=> int_mask);

   assert_pc_advance_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> pc == $past(addr) + ADDR_W'(1));

endmodule

bind entry_seq entry_seq_checker #(
   .DATA_W     (DATA_W),
   .ADDR_W     (ADDR_W),
   .STACK_PAGE (STACK_PAGE)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .addr     (addr),
   .rw       (rw),
   .done     (done),
   .sp       (sp),
   .ir       (ir),
   .pc       (pc),
   .int_mask (int_mask),
   .in_stack (in_stack),
   .in_seq   (in_seq)
);

// File: tb/entry_seq_bench.sv
module entry_seq_bench;

   localparam int CLK_PERIOD = 10;
   localparam int TBL_N      = 6;
   // each row: {addr, rw, done, din to present}
   localparam logic [25:0] RST_TBL [TBL_N] = '{
      {16'h0100, 1'b1, 1'b0, 8'h55},
      {16'h01FF, 1'b1, 1'b0, 8'h66},
      {16'h01FE, 1'b1, 1'b0, 8'h77},
      {16'hFFFC, 1'b1, 1'b0, 8'h34},
      {16'hFFFD, 1'b1, 1'b0, 8'h12},
      {16'h1234, 1'b1, 1'b1, 8'hEA}
   };
   localparam logic [7:0] PSR = 8'hA5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        nmi_req = 1'b0;
   logic        irq_req = 1'b0;
   logic        brk_req = 1'b0;
   logic [7:0]  psr_in = PSR;
   logic [7:0]  din = 8'h00;
   logic [15:0] addr;
   logic        rw;
   logic [7:0]  dout;
   logic        done;
   logic [7:0]  sp;
   logic [7:0]  ir;
   logic [15:0] pc;
   logic        int_mask;

   int n_checks = 0;
   int n_fail   = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   entry_seq u_entry_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .nmi_req  (nmi_req),
      .irq_req  (irq_req),
      .brk_req  (brk_req),
      .psr_in   (psr_in),
      .din      (din),
      .addr     (addr),
      .rw       (rw),
      .dout     (dout),
      .done     (done),
      .sp       (sp),
      .ir       (ir),
      .pc       (pc),
      .int_mask (int_mask)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic check_hold();
      chk(rw == 1'b1, "R1", "rw in reset", 32'(rw), 1);
      chk(sp == 8'h00, "R1", "sp in reset", 32'(sp), 0);
      chk(ir == 8'h00, "R1", "ir in reset", 32'(ir), 0);
      chk(done == 1'b0, "R1", "done in reset", 32'(done), 0);
      chk(int_mask == 1'b0, "R1", "mask in reset", 32'(int_mask), 0);
   endtask

   task automatic walk_reset();
      for (int i = 0; i < TBL_N; i++) begin
         step();
         chk(addr == RST_TBL[i][25:10], (i < 3) ? "R2" : "R3", "reset addr",
             32'(addr), 32'(RST_TBL[i][25:10]));
         chk(rw == RST_TBL[i][9], "R2", "reset rw", 32'(rw), 32'(RST_TBL[i][9]));
         chk(done == RST_TBL[i][8], "R3", "reset done", 32'(done), 32'(RST_TBL[i][8]));
         if (i < TBL_N - 1)
            chk(ir == 8'h00, "R4", "ir during reset entry", 32'(ir), 0);
         if (i < 3)
            chk(sp == 8'(8'h00 - i), "R2", "sp before stack cycle", 32'(sp), 32'(8'(8'h00 - i)));
         din = RST_TBL[i][7:0];
      end
      step();
      chk(sp == 8'hFD, "R2", "sp after reset", 32'(sp), 32'hFD);
      chk(ir == 8'hEA, "R4", "ir loaded", 32'(ir), 32'hEA);
      chk(pc == 16'h1235, "R9", "pc after fetch", 32'(pc), 32'h1235);
      chk(addr == 16'h1235 && rw, "R9", "run addr", 32'(addr), 32'h1235);
      chk(done == 1'b0, "R3", "done one cycle", 32'(done), 0);
      chk(int_mask == 1'b1, "R8", "mask after reset", 32'(int_mask), 1);
   endtask

   // called with requests already raised, in the run state
   task automatic run_entry(input logic [15:0] vbase, input logic [7:0] sp0,
                            input logic [15:0] pc0, input logic [15:0] nvec,
                            input logic [7:0] op, input string rq);
      logic [7:0] exp_d;
      for (int k = 0; k < 3; k++) begin
         step();
         nmi_req = 1'b0;
         brk_req = 1'b0;
         if (k == 2) irq_req = 1'b0;
         exp_d = (k == 0) ? pc0[15:8] : (k == 1) ? pc0[7:0] : PSR;
         chk(addr == {8'h01, 8'(sp0 - k)}, "R5", "push addr", 32'(addr),
             32'({8'h01, 8'(sp0 - k)}));
         chk(rw == 1'b0, "R5", "push is write", 32'(rw), 0);
         chk(dout == exp_d, "R5", "push data", 32'(dout), 32'(exp_d));
         chk(ir == 8'h00, "R4", "ir during entry", 32'(ir), 0);
         chk(int_mask == 1'b1, "R8", "mask during entry", 32'(int_mask), 1);
      end
      step();
      chk(addr == vbase && rw, rq, "vector low addr", 32'(addr), 32'(vbase));
      din = nvec[7:0];
      step();
      chk(addr == vbase + 16'd1 && rw, rq, "vector high addr", 32'(addr), 32'(vbase + 16'd1));
      din = nvec[15:8];
      step();
      chk(addr == nvec && done, "R3", "fetch at vector", 32'(addr), 32'(nvec));
      din = op;
      step();
      chk(ir == op, "R4", "opcode loaded", 32'(ir), 32'(op));
      chk(pc == nvec + 16'd1 && addr == pc, "R9", "pc after entry", 32'(pc), 32'(nvec + 16'd1));
      chk(sp == 8'(sp0 - 3), "R5", "sp after pushes", 32'(sp), 32'(8'(sp0 - 3)));
      step();
      chk(addr == nvec + 16'd1 && !done, "R7", "late request ignored", 32'(addr),
          32'(nvec + 16'd1));
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 5000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin : stim
      step();
      step();
      check_hold();
      rst_n = 1'b1;
      walk_reset();

      // idle run state keeps pc
      step();
      step();
      chk(addr == 16'h1235 && rw && !done, "R9", "run state steady", 32'(addr), 32'h1235);

      // non-maskable with maskable held through the stack cycles
      nmi_req = 1'b1;
      irq_req = 1'b1;
      run_entry(16'hFFFA, 8'hFD, 16'h1235, 16'h2000, 8'h40, "R7");

      irq_req = 1'b1;
      run_entry(16'hFFFE, 8'hFA, 16'h2001, 16'h3000, 8'h41, "R6");

      brk_req = 1'b1;
      run_entry(16'hFFFE, 8'hF7, 16'h3001, 16'h4000, 8'h42, "R6");

      nmi_req = 1'b1;
      run_entry(16'hFFFA, 8'hF4, 16'h4001, 16'h5000, 8'h43, "R6");

      irq_req = 1'b1;
      brk_req = 1'b1;
      run_entry(16'hFFFE, 8'hF1, 16'h5001, 16'h6000, 8'h44, "R7");

      // reset during an interrupt push
      irq_req = 1'b1;
      step();
      irq_req = 1'b0;
      step();
      rst_n = 1'b0;
      #1;
      check_hold();
      step();
      check_hold();
      rst_n = 1'b1;
      walk_reset();

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule